// File: doc/BRIEF.md
# PWM Channel Counter with Compare

This block generates one pulse-width-modulated output. It counts down once for each tick strobe, through a period of `period_val + 1` ticks. While the count is at or below the compare value, the output is high. A 4-bit control field sets the channel's behaviour:

- enable,
- output inversion,
- continuous or single-shot operation.

A one-cycle `period_done` pulse marks each wrap of the count. The live count is also brought out. Clock division and bus access belong to the surrounding logic. The tick strobe stands in for the divided clock.

No data stream passes through the block, so it has no valid/ready pairs. Every pin is a plain control or status level. A caller sets the period and compare inputs at any time. The channel samples them only when it starts and at each wrap, so no period is ever cut short. The invert bit is different: it acts on the output pin at once.

Top module: `pwm_chan`

## Requirements
- R1: After reset, `pwm_out` is 0 (with invert clear), `period_done` is 0 and `count` is 0.
- R2: Control field bits: bit 0 is enable, bit 2 is invert, bit 3 selects continuous mode (1) or single-shot mode (0). Bit 1 has no effect.
- R3: The first clock edge that sees enable on an idle channel loads `count` with `period_val`, whatever the tick input is. After that, each edge with `tick` high lowers `count` by one. An edge without tick leaves `count` unchanged.
- R4: An edge with `tick` high while `count` is 0 raises `period_done` for the next cycle only. In continuous mode, the same edge reloads `count` with `period_val`.
- R5: When 0 < period and compare < period, the un-inverted output is high exactly while `count` <= compare. That gives compare + 1 high ticks out of period + 1.
- R6: When the period is nonzero and compare >= period, the un-inverted output stays high for the whole period.
- R7: When the period is 0, the un-inverted output stays low, and `period_done` pulses after every tick.
- R8: A disabled channel drives `pwm_out` equal to the invert bit and holds `count` at 0.
- R9: Invert complements the output after rules R5 to R8 have been applied. A change of the invert bit shows on `pwm_out` in the same cycle and does not restart the count.
- R10: In single-shot mode the channel runs one period and pulses `period_done`. It then stops with `count` 0 and the idle level on `pwm_out`. It starts again only after enable has been low for at least one edge.
- R11: The channel samples `period_val` and `cmp_val` only at start and at a continuous-mode reload. A change between those points does not affect the period in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one step per high cycle |
| period_val | input | W | Period setting, period is this plus one ticks |
| cmp_val | input | W | Compare setting for the high time |
| ctrl | input | 4 | Control field: enable, reserved, invert, mode |
| pwm_out | output | 1 | PWM output pin |
| period_done | output | 1 | One-cycle pulse after each wrap of the count |
| count | output | W | Live down-count value |

## Verification
The bench builds the channel with an 8-bit width. This keeps every period short, so each case fits in a few cycles:

- a full continuous period including its wrap and reload,
- a period of zero that wraps on every tick,
- a compare at or above the period,
- a single-shot run followed by its restart.

Expected output, pulse and count values are worked out by hand for each edge. A scoreboard queue holds them, and they are compared one cycle at a time. This covers invert changes in the middle of a period and a setting change just before a wrap.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int CTRL_W        = 4;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_INV_BIT  = 2;
  localparam int CTRL_MODE_BIT = 3;

  typedef struct packed {
    logic en;
    logic inv;
    logic cont;
  } chan_ctrl_t;

  function automatic chan_ctrl_t decode_ctrl(input logic [CTRL_W-1:0] f);
    chan_ctrl_t c;
    c.en   = f[CTRL_EN_BIT];
    c.inv  = f[CTRL_INV_BIT];
    c.cont = f[CTRL_MODE_BIT];
    return c;
  endfunction
endpackage

// File: rtl/pwm_chan_shadow.sv
module pwm_chan_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] period_val,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] sh_per,
  output logic [W-1:0] sh_cmp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_per <= '0;
      sh_cmp <= '0;
    end else if (load) begin
      sh_per <= period_val;
      sh_cmp <= cmp_val;
    end
  end
endmodule

// File: rtl/pwm_chan_seq.sv
module pwm_chan_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         cont,
  input  logic [W-1:0] period_val,
  output logic         load,
  output logic         running,
  output logic         done,
  output logic [W-1:0] count
);
  logic shot_over;
  logic start;
  logic wrap;

  assign start = en && !running && !shot_over;
  assign wrap  = running && tick && (count == '0);
  assign load  = start || (wrap && cont);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      shot_over <= 1'b0;
      done      <= 1'b0;
      count     <= '0;
    end else if (!en) begin
      running   <= 1'b0;
      shot_over <= 1'b0;
      done      <= 1'b0;
      count     <= '0;
    end else begin
      done <= wrap;
      if (start) begin
        running <= 1'b1;
        count   <= period_val;
      end else if (wrap) begin
        if (cont) begin
          count <= period_val;
        end else begin
          running   <= 1'b0;
          shot_over <= 1'b1;
          count     <= '0;
        end
      end else if (running && tick) begin
        count <= count - 1'b1;
      end
    end
  end

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(en && running && tick && count == '0)); // R4

  AST_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap && !cont) |=> (!running && count == '0)); // R10
endmodule

// File: rtl/pwm_chan_level.sv
module pwm_chan_level #(
  parameter int W = 16
) (
  input  logic         running,
  input  logic         inv,
  input  logic [W-1:0] count,
  input  logic [W-1:0] sh_per,
  input  logic [W-1:0] sh_cmp,
  output logic         pwm
);
  logic lvl;

  always_comb begin
    if (!running)               lvl = 1'b0;
    else if (sh_per == '0)      lvl = 1'b0;
    else if (sh_cmp >= sh_per)  lvl = 1'b1;
    else                        lvl = (count <= sh_cmp);
  end

  assign pwm = lvl ^ inv;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [W-1:0]      period_val,
  input  logic [W-1:0]      cmp_val,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              pwm_out,
  output logic              period_done,
  output logic [W-1:0]      count
);
  chan_ctrl_t   c;
  logic         ctrl_unused;
  logic         load;
  logic         running;
  logic [W-1:0] sh_per;
  logic [W-1:0] sh_cmp;

  assign c           = decode_ctrl(ctrl);
  assign ctrl_unused = ctrl[1];

  pwm_chan_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(c.en), .cont(c.cont),
    .period_val(period_val), .load(load), .running(running),
    .done(period_done), .count(count)
  );

  pwm_chan_shadow #(.W(W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load), .period_val(period_val),
    .cmp_val(cmp_val), .sh_per(sh_per), .sh_cmp(sh_cmp)
  );

  pwm_chan_level #(.W(W)) u_level (
    .running(running), .inv(c.inv), .count(count), .sh_per(sh_per),
    .sh_cmp(sh_cmp), .pwm(pwm_out)
  );

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (count <= sh_per)); // R3

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load) |=> ($stable(sh_per) && $stable(sh_cmp))); // R11

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CTRL_EN_BIT] |=> (pwm_out == ctrl[CTRL_INV_BIT] && count == '0)); // R8
endmodule

// File: tb/tb_pwm_chan.sv
`timescale 1ns/100ps
module tb_pwm_chan;
  localparam int W = 8;
  localparam logic [3:0] OFF  = 4'b0000;
  localparam logic [3:0] OFFI = 4'b0100;
  localparam logic [3:0] RUN  = 4'b1001;
  localparam logic [3:0] RUNI = 4'b1101;
  localparam logic [3:0] RUNB = 4'b1011;
  localparam logic [3:0] SHOT = 4'b0001;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [W-1:0] period_val = '0;
  logic [W-1:0] cmp_val = '0;
  logic [3:0]   ctrl = '0;
  logic         pwm_out;
  logic         period_done;
  logic [W-1:0] count;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  o;
    logic  d;
    int    c;
    string r;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  pwm_chan #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_val(period_val),
    .cmp_val(cmp_val), .ctrl(ctrl), .pwm_out(pwm_out),
    .period_done(period_done), .count(count)
  );

  task automatic step(input logic tk, input logic [3:0] ct, input int pv,
                      input int cv, input logic eo, input logic ed,
                      input int ec, input string rq);
    @(negedge clk);
    tick = tk; ctrl = ct; period_val = pv[W-1:0]; cmp_val = cv[W-1:0];
    @(posedge clk);
    q.push_back('{eo, ed, ec, rq});
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (pwm_out !== e.o || period_done !== e.d || int'(count) != e.c) begin
          errors++;
          $display("FAIL %s: out=%b done=%b count=%0d expected out=%b done=%b count=%0d",
                   e.r, pwm_out, period_done, count, e.o, e.d, e.c);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, OFF, 0, 0, 0, 0, 0, "R1");
    // R3 R5 R4: period 3, compare 1, continuous
    step(1, RUN, 3, 1, 0, 0, 3, "R3");
    step(1, RUN, 3, 1, 0, 0, 2, "R5");
    step(1, RUN, 3, 1, 1, 0, 1, "R5");
    step(1, RUN, 3, 1, 1, 0, 0, "R5");
    step(1, RUN, 3, 1, 0, 1, 3, "R4");
    step(1, RUN, 3, 1, 0, 0, 2, "R4");
    step(1, RUN, 3, 1, 1, 0, 1, "R5");
    step(0, RUN, 3, 1, 1, 0, 1, "R3");
    // R9: invert live, count keeps going
    step(0, RUNI, 3, 1, 0, 0, 1, "R9");
    step(1, RUNI, 3, 1, 0, 0, 0, "R9");
    step(1, RUNI, 3, 1, 1, 1, 3, "R9");
    step(1, RUN, 3, 1, 0, 0, 2, "R9");
    // R2: reserved bit has no effect
    step(1, RUNB, 3, 1, 1, 0, 1, "R2");
    // R11: new settings wait for the wrap; R6 after reload
    step(1, RUN, 5, 5, 1, 0, 0, "R11");
    step(1, RUN, 5, 5, 1, 1, 5, "R6");
    step(1, RUN, 5, 5, 1, 0, 4, "R6");
    step(1, RUN, 5, 5, 1, 0, 3, "R6");
    // R8: disabled level follows invert
    step(0, OFFI, 5, 5, 1, 0, 0, "R8");
    step(0, OFF, 5, 5, 0, 0, 0, "R8");
    // R7: zero period
    step(1, RUN, 0, 0, 0, 0, 0, "R7");
    step(1, RUN, 0, 0, 0, 1, 0, "R7");
    step(1, RUN, 0, 0, 0, 1, 0, "R7");
    step(1, RUNI, 0, 0, 1, 1, 0, "R9");
    step(0, OFF, 0, 0, 0, 0, 0, "R8");
    // R10: single shot, period 2, compare 0
    step(1, SHOT, 2, 0, 0, 0, 2, "R10");
    step(1, SHOT, 2, 0, 0, 0, 1, "R10");
    step(1, SHOT, 2, 0, 1, 0, 0, "R10");
    step(1, SHOT, 2, 0, 0, 1, 0, "R10");
    step(1, SHOT, 2, 0, 0, 0, 0, "R10");
    step(1, SHOT, 2, 0, 0, 0, 0, "R10");
    step(0, OFF, 2, 0, 0, 0, 0, "R10");
    step(1, SHOT, 2, 0, 0, 0, 2, "R10");
    step(1, SHOT, 2, 0, 0, 0, 1, "R10");
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule